// File: doc/BRIEF.md
# Partially Populated Large-Page Translation Buffer

This block is a small, fully associative translation buffer. Each entry can stand for a naturally aligned run of contiguous 4 KiB pages that together form one large page. An entry does not have to hold the whole run. A per-page presence mask records which pages of the run have been installed, and the mask takes part in the match in the same way as the tag does. A page whose mask bit is clear misses, even when its group tag matches.

A lookup request presents a virtual page number. One cycle later the block returns a hit flag, the physical page number and the permission and memory-type bits. An external walker supplies misses through the fill port, one page-table entry per cycle. The fill carries a contiguity hint, and the group size is encoded in the low physical-page bits of that entry.

When an entry for the same group already exists and agrees on physical base, permissions and memory type, the fill sets one more mask bit and takes no new entry. When the new page disagrees with that entry, the page is kept apart as a single-page entry. When no entry for the group exists, a new entry is allocated. Allocation takes a free slot first and otherwise replaces in round-robin order. A flush input empties the buffer in one cycle.

Top module: `tlbm_cpg_tlb`

## Requirements
- R1: A lookup request (`lk_req_i`=1) raises `lk_rsp_o` in the following cycle together with its result. A cycle without a request leaves `lk_rsp_o` low. On a miss, `lk_hit_o`=0 and the page, permission and memory-type outputs are all zero.
- R2: With `fill_contig_i`=1, let t be the number of consecutive ones counted upward from bit 0 of `fill_ppn_i`, looking at bits 3:0 only. For t in 0..3 the group holds 2^(t+1) pages, and its physical base is `fill_ppn_i` with the low t+1 bits cleared. For t=4 (low nibble 1111), or when `fill_contig_i`=0, the fill is a single page mapped to `fill_ppn_i` as given.
- R3: A fill that allocates a group entry sets only the mask bit of the filled page. The other pages of the group keep missing.
- R4: A lookup hits only when an entry's group-aligned virtual tag matches and the mask bit indexed by the low virtual bits within the group is set. The returned page is the group base ORed with those low bits, and the permissions and memory type come from the entry.
- R5: A fill to a page of an existing group entry with the same group size, equal physical base, equal permissions and equal memory type sets that page's mask bit and allocates no entry.
- R6: A fill to a page of an existing group entry whose physical base, permissions or memory type differ is installed as a single-page entry. That entry carries the new page's own translation. The existing entry's pages are left unchanged.
- R7: A fill whose page already hits in the buffer has no effect.
- R8: A fill that needs a new entry uses the lowest-numbered invalid entry. When every entry is valid, it replaces entries round-robin. The round-robin order starts at entry 0 after reset or flush and advances by one per replacement.
- R9: `flush_i` invalidates every entry and clears every mask in one cycle. It also returns the round-robin pointer to entry 0. A fill in the same cycle as a flush is dropped.
- R10: A lookup in the same cycle as a fill or flush returns the state from before that update.
- R11: After reset every entry is invalid and `lk_rsp_o` and `lk_hit_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| lk_req_i | input | 1 | Lookup request |
| lk_vpn_i | input | 20 | Lookup virtual page number |
| lk_rsp_o | output | 1 | Lookup result valid, one cycle after request |
| lk_hit_o | output | 1 | Lookup hit |
| lk_ppn_o | output | 20 | Translated physical page number |
| lk_perm_o | output | 4 | Permission bits of the hit |
| lk_mtype_o | output | 2 | Memory type of the hit |
| fill_i | input | 1 | Install one page-table entry |
| fill_vpn_i | input | 20 | Virtual page number being filled |
| fill_ppn_i | input | 20 | Physical page field, low bits carry the group size when contiguous |
| fill_contig_i | input | 1 | Contiguous-group hint |
| fill_perm_i | input | 4 | Permission bits of the filled page |
| fill_mtype_i | input | 2 | Memory type of the filled page |

## Verification
The bench installs one page of a 16-page group and probes a sibling page. A design that ignored the mask would hit there and return a made-up translation. It then merges a second page and fills the buffer with seven more singles. A design that allocated on the merge would lose the group to round-robin eviction. The bench also sends group members whose base, permissions or memory type disagree with the entry; a design that merged them would return the old entry's fields or corrupt its neighbours. Further corners covered are the oversize nibble pattern, a refill of an already present page, a lookup in the same cycle as a fill or flush, and the round-robin pointer after a flush.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
    localparam int VPN_W        = 20;
    localparam int PPN_W        = 20;
    localparam int PERM_W       = 4;
    localparam int MT_W         = 2;
    localparam int GRP_LOG2_MAX = 4;
    localparam int GRP_PAGES    = 1 << GRP_LOG2_MAX;
    localparam int LG_W         = $clog2(GRP_LOG2_MAX + 1);

    typedef struct packed {
        logic                 valid;
        logic [LG_W-1:0]      lg;
        logic [VPN_W-1:0]     vtag;
        logic [PPN_W-1:0]     pbase;
        logic [PERM_W-1:0]    perm;
        logic [MT_W-1:0]      mt;
        logic [GRP_PAGES-1:0] mask;
    } tlb_ent_t;

    // low lg bits set: selects the page offset inside a group
    function automatic logic [GRP_LOG2_MAX-1:0] grp_mask(input logic [LG_W-1:0] lg);
        logic [GRP_LOG2_MAX-1:0] m;
        m = '0;
        for (int i = 0; i < GRP_LOG2_MAX; i++) begin
            if (i < int'(lg)) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/tlbm_grp_dec.sv
module tlbm_grp_dec
    import tlbm_pkg::*;
(
    input  logic                    contig_i,
    input  logic [VPN_W-1:0]        vpn_i,
    input  logic [PPN_W-1:0]        ppn_i,
    output logic [LG_W-1:0]         lg_o,
    output logic [VPN_W-1:0]        tag_o,
    output logic [PPN_W-1:0]        base_o,
    output logic [GRP_LOG2_MAX-1:0] off_o
);
    logic [LG_W-1:0]         ones;
    logic [GRP_LOG2_MAX-1:0] m;

    // count the run of ones from bit 0 of the page field
    always_comb begin
        logic run;
        run  = 1'b1;
        ones = '0;
        for (int i = 0; i < GRP_LOG2_MAX; i++) begin
            if (run && ppn_i[i]) ones = ones + LG_W'(1);
            else                 run  = 1'b0;
        end
    end

    always_comb begin
        if (contig_i && (ones < LG_W'(GRP_LOG2_MAX))) lg_o = ones + LG_W'(1);
        else                                          lg_o = '0;
    end

    assign m      = grp_mask(lg_o);
    assign off_o  = vpn_i[GRP_LOG2_MAX-1:0] & m;
    assign tag_o  = vpn_i & ~{{(VPN_W-GRP_LOG2_MAX){1'b0}}, m};
    assign base_o = ppn_i & ~{{(PPN_W-GRP_LOG2_MAX){1'b0}}, m};
endmodule

// File: rtl/tlbm_hit_vec.sv
module tlbm_hit_vec
    import tlbm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]                valid_i,
    input  logic [N-1:0][LG_W-1:0]      lg_i,
    input  logic [N-1:0][VPN_W-1:0]     vtag_i,
    input  logic [N-1:0][GRP_PAGES-1:0] mask_i,
    input  logic [VPN_W-1:0]            vpn_i,
    output logic [N-1:0]                hit_o
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [GRP_LOG2_MAX-1:0] m;
        logic [GRP_LOG2_MAX-1:0] off;
        logic                    tag_ok;
        assign m      = grp_mask(lg_i[g]);
        assign off    = vpn_i[GRP_LOG2_MAX-1:0] & m;
        assign tag_ok = (vpn_i & ~{{(VPN_W-GRP_LOG2_MAX){1'b0}}, m}) == vtag_i[g];
        // presence bit is part of the associative match
        assign hit_o[g] = valid_i[g] & tag_ok & mask_i[g][off];
    end
endmodule

// File: rtl/tlbm_victim.sv
module tlbm_victim #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     valid_i,
    input  logic [IDX_W-1:0] rr_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             use_rr_o
);
    always_comb begin
        idx_o    = rr_i;
        use_rr_o = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                idx_o    = IDX_W'(i);
                use_rr_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/tlbm_cpg_tlb.sv
module tlbm_cpg_tlb
    import tlbm_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic              lk_req_i,
    input  logic [VPN_W-1:0]  lk_vpn_i,
    output logic              lk_rsp_o,
    output logic              lk_hit_o,
    output logic [PPN_W-1:0]  lk_ppn_o,
    output logic [PERM_W-1:0] lk_perm_o,
    output logic [MT_W-1:0]   lk_mtype_o,
    input  logic              fill_i,
    input  logic [VPN_W-1:0]  fill_vpn_i,
    input  logic [PPN_W-1:0]  fill_ppn_i,
    input  logic              fill_contig_i,
    input  logic [PERM_W-1:0] fill_perm_i,
    input  logic [MT_W-1:0]   fill_mtype_i
);
    localparam int IDX_W = $clog2(NUM_ENTRIES);
    localparam int PAD_W = PPN_W - GRP_LOG2_MAX;

    typedef struct packed {
        tlb_ent_t [NUM_ENTRIES-1:0] ent;
        logic [IDX_W-1:0]           rr;
        logic                       rsp;
        logic                       hit;
        logic [PPN_W-1:0]           ppn;
        logic [PERM_W-1:0]          perm;
        logic [MT_W-1:0]            mt;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_ENTRIES-1:0]                valid_vec;
    logic [NUM_ENTRIES-1:0][LG_W-1:0]      lg_arr;
    logic [NUM_ENTRIES-1:0][VPN_W-1:0]     tag_arr;
    logic [NUM_ENTRIES-1:0][GRP_PAGES-1:0] mask_arr;
    logic [NUM_ENTRIES-1:0]                cand_vec;
    logic [NUM_ENTRIES-1:0]                cons_vec;
    logic [NUM_ENTRIES-1:0]                lk_hv;
    logic [NUM_ENTRIES-1:0]                fill_hv;

    logic [LG_W-1:0]         f_lg;
    logic [VPN_W-1:0]        f_tag;
    logic [PPN_W-1:0]        f_base;
    logic [GRP_LOG2_MAX-1:0] f_off;
    logic [IDX_W-1:0]        vic_idx;
    logic                    vic_rr;
    logic                    merge_ok;
    logic                    cand_any;
    logic                    fill_go;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_view
        assign valid_vec[g] = state_q.ent[g].valid;
        assign lg_arr[g]    = state_q.ent[g].lg;
        assign tag_arr[g]   = state_q.ent[g].vtag;
        assign mask_arr[g]  = state_q.ent[g].mask;
        // same group, same size: merge candidate
        assign cand_vec[g]  = state_q.ent[g].valid && (f_lg != '0) &&
                              (state_q.ent[g].lg == f_lg) && (state_q.ent[g].vtag == f_tag);
        // member agrees with the entry it would join
        assign cons_vec[g]  = (state_q.ent[g].pbase == f_base) &&
                              (state_q.ent[g].perm == fill_perm_i) &&
                              (state_q.ent[g].mt == fill_mtype_i);
    end

    tlbm_grp_dec u_dec (
        .contig_i (fill_contig_i),
        .vpn_i    (fill_vpn_i),
        .ppn_i    (fill_ppn_i),
        .lg_o     (f_lg),
        .tag_o    (f_tag),
        .base_o   (f_base),
        .off_o    (f_off)
    );

    tlbm_hit_vec #(.N(NUM_ENTRIES)) u_lk_hits (
        .valid_i (valid_vec),
        .lg_i    (lg_arr),
        .vtag_i  (tag_arr),
        .mask_i  (mask_arr),
        .vpn_i   (lk_vpn_i),
        .hit_o   (lk_hv)
    );

    tlbm_hit_vec #(.N(NUM_ENTRIES)) u_fill_hits (
        .valid_i (valid_vec),
        .lg_i    (lg_arr),
        .vtag_i  (tag_arr),
        .mask_i  (mask_arr),
        .vpn_i   (fill_vpn_i),
        .hit_o   (fill_hv)
    );

    tlbm_victim #(.N(NUM_ENTRIES)) u_vic (
        .valid_i  (valid_vec),
        .rr_i     (state_q.rr),
        .idx_o    (vic_idx),
        .use_rr_o (vic_rr)
    );

    assign merge_ok = |(cand_vec & cons_vec);
    assign cand_any = |cand_vec;
    assign fill_go  = fill_i && !flush_i && !(|fill_hv);

    // lookup field select
    logic [LG_W-1:0]         sel_lg;
    logic [PPN_W-1:0]        sel_pbase;
    logic [PERM_W-1:0]       sel_perm;
    logic [MT_W-1:0]         sel_mt;
    logic [GRP_LOG2_MAX-1:0] sel_off;

    always_comb begin
        sel_lg    = '0;
        sel_pbase = '0;
        sel_perm  = '0;
        sel_mt    = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (lk_hv[i]) begin
                sel_lg    = state_q.ent[i].lg;
                sel_pbase = state_q.ent[i].pbase;
                sel_perm  = state_q.ent[i].perm;
                sel_mt    = state_q.ent[i].mt;
            end
        end
    end

    assign sel_off = lk_vpn_i[GRP_LOG2_MAX-1:0] & grp_mask(sel_lg);

    always_comb begin
        tlb_ent_t ne;
        state_d     = state_q;
        state_d.rsp = lk_req_i;
        state_d.hit = lk_req_i && (|lk_hv);
        if (lk_req_i && (|lk_hv)) begin
            state_d.ppn  = sel_pbase | {{PAD_W{1'b0}}, sel_off};
            state_d.perm = sel_perm;
            state_d.mt   = sel_mt;
        end else begin
            state_d.ppn  = '0;
            state_d.perm = '0;
            state_d.mt   = '0;
        end

        ne       = '0;
        ne.valid = 1'b1;
        ne.perm  = fill_perm_i;
        ne.mt    = fill_mtype_i;
        if (cand_any) begin
            // disagreeing member: keep it apart as a single page
            ne.lg    = '0;
            ne.vtag  = fill_vpn_i;
            ne.pbase = f_base | {{PAD_W{1'b0}}, f_off};
            ne.mask  = GRP_PAGES'(1);
        end else begin
            ne.lg    = f_lg;
            ne.vtag  = f_tag;
            ne.pbase = f_base;
            ne.mask  = GRP_PAGES'(1) << f_off;
        end

        if (flush_i) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                state_d.ent[i].valid = 1'b0;
                state_d.ent[i].mask  = '0;
            end
            state_d.rr = '0;
        end else if (fill_go) begin
            if (merge_ok) begin
                for (int i = 0; i < NUM_ENTRIES; i++) begin
                    if (cand_vec[i] && cons_vec[i]) state_d.ent[i].mask[f_off] = 1'b1;
                end
            end else begin
                state_d.ent[vic_idx] = ne;
                if (vic_rr) begin
                    state_d.rr = (state_q.rr == IDX_W'(NUM_ENTRIES - 1)) ? '0
                                                                        : state_q.rr + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign lk_rsp_o   = state_q.rsp;
    assign lk_hit_o   = state_q.hit;
    assign lk_ppn_o   = state_q.ppn;
    assign lk_perm_o  = state_q.perm;
    assign lk_mtype_o = state_q.mt;

    p_rsp_follows_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_req_i |=> lk_rsp_o);
    p_rsp_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lk_req_i |=> !lk_rsp_o);
    p_merge_no_alloc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fill_go && merge_ok) |=> $stable(valid_vec));
    p_single_cover_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(lk_hv));
    p_present_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fill_i && !flush_i && (|fill_hv)) |=> $stable(state_q.ent));
    p_flush_empties_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (valid_vec == '0));
endmodule

// File: tb/test_tlbm_cpg_tlb.sv
`timescale 1ns/1ps
module test_tlbm_cpg_tlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_req = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        lk_rsp, lk_hit;
    logic [19:0] lk_ppn;
    logic [3:0]  lk_perm;
    logic [1:0]  lk_mt;
    logic        fill = 1'b0;
    logic [19:0] f_vpn = '0, f_ppn = '0;
    logic        f_contig = 1'b0;
    logic [3:0]  f_perm = '0;
    logic [1:0]  f_mt = '0;
    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    tlbm_cpg_tlb i_tlbm_cpg_tlb (
        .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
        .lk_req_i(lk_req), .lk_vpn_i(lk_vpn), .lk_rsp_o(lk_rsp), .lk_hit_o(lk_hit),
        .lk_ppn_o(lk_ppn), .lk_perm_o(lk_perm), .lk_mtype_o(lk_mt),
        .fill_i(fill), .fill_vpn_i(f_vpn), .fill_ppn_i(f_ppn), .fill_contig_i(f_contig),
        .fill_perm_i(f_perm), .fill_mtype_i(f_mt)
    );

    typedef struct packed {
        logic        is_fill;
        logic [19:0] vpn;
        logic [19:0] ppn;
        logic        contig;
        logic [3:0]  perm;
        logic [1:0]  mt;
        logic        eh;
        logic [19:0] ep;
        logic [3:0]  eperm;
        logic [1:0]  emt;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 20'h00100, 20'h0,     1'b0, 4'h0, 2'd0, 1'b0, 20'h0,     4'h0, 2'd0, 8'd11}, // R11 empty
        '{1'b1, 20'h00103, 20'h50007, 1'b1, 4'hB, 2'd1, 1'b0, 20'h0,     4'h0, 2'd0, 8'd2},  // R2 16-page group
        '{1'b0, 20'h00103, 20'h0,     1'b0, 4'h0, 2'd0, 1'b1, 20'h50003, 4'hB, 2'd1, 8'd4},  // R4
        '{1'b0, 20'h00105, 20'h0,     1'b0, 4'h0, 2'd0, 1'b0, 20'h0,     4'h0, 2'd0, 8'd3},  // R3 sibling absent
        '{1'b1, 20'h00105, 20'h50007, 1'b1, 4'hB, 2'd1, 1'b0, 20'h0,     4'h0, 2'd0, 8'd5},  // R5 merge
        '{1'b0, 20'h00105, 20'h0,     1'b0, 4'h0, 2'd0, 1'b1, 20'h50005, 4'hB, 2'd1, 8'd5},
        '{1'b0, 20'h00103, 20'h0,     1'b0, 4'h0, 2'd0, 1'b1, 20'h50003, 4'hB, 2'd1, 8'd5},
        '{1'b1, 20'h00108, 20'h60007, 1'b1, 4'hB, 2'd1, 1'b0, 20'h0,     4'h0, 2'd0, 8'd6},  // R6 base differs
        '{1'b0, 20'h00108, 20'h0,     1'b0, 4'h0, 2'd0, 1'b1, 20'h60008, 4'hB, 2'd1, 8'd6},
        '{1'b0, 20'h00105, 20'h0,     1'b0, 4'h0, 2'd0, 1'b1, 20'h50005, 4'hB, 2'd1, 8'd6},
        '{1'b1, 20'h0010A, 20'h50007, 1'b1, 4'h3, 2'd1, 1'b0, 20'h0,     4'h0, 2'd0, 8'd6},  // R6 perm differs
        '{1'b0, 20'h0010A, 20'h0,     1'b0, 4'h0, 2'd0, 1'b1, 20'h5000A, 4'h3, 2'd1, 8'd6},
        '{1'b1, 20'h0010C, 20'h50007, 1'b1, 4'hB, 2'd2, 1'b0, 20'h0,     4'h0, 2'd0, 8'd6},  // R6 type differs
        '{1'b0, 20'h0010C, 20'h0,     1'b0, 4'h0, 2'd0, 1'b1, 20'h5000C, 4'hB, 2'd2, 8'd6},
        '{1'b1, 20'h00105, 20'h77777, 1'b0, 4'h1, 2'd0, 1'b0, 20'h0,     4'h0, 2'd0, 8'd7},  // R7 refill present
        '{1'b0, 20'h00105, 20'h0,     1'b0, 4'h0, 2'd0, 1'b1, 20'h50005, 4'hB, 2'd1, 8'd7},
        '{1'b1, 20'h00201, 20'h12340, 1'b0, 4'h5, 2'd3, 1'b0, 20'h0,     4'h0, 2'd0, 8'd2},  // R2 plain page
        '{1'b0, 20'h00201, 20'h0,     1'b0, 4'h0, 2'd0, 1'b1, 20'h12340, 4'h5, 2'd3, 8'd2},
        '{1'b1, 20'h00301, 20'h4000E, 1'b1, 4'h7, 2'd0, 1'b0, 20'h0,     4'h0, 2'd0, 8'd2},  // R2 2-page group
        '{1'b0, 20'h00301, 20'h0,     1'b0, 4'h0, 2'd0, 1'b1, 20'h4000F, 4'h7, 2'd0, 8'd2},
        '{1'b0, 20'h00300, 20'h0,     1'b0, 4'h0, 2'd0, 1'b0, 20'h0,     4'h0, 2'd0, 8'd3},
        '{1'b1, 20'h00401, 20'h3000F, 1'b1, 4'h2, 2'd1, 1'b0, 20'h0,     4'h0, 2'd0, 8'd2},  // R2 oversize
        '{1'b0, 20'h00401, 20'h0,     1'b0, 4'h0, 2'd0, 1'b1, 20'h3000F, 4'h2, 2'd1, 8'd2},
        '{1'b0, 20'h00400, 20'h0,     1'b0, 4'h0, 2'd0, 1'b0, 20'h0,     4'h0, 2'd0, 8'd2}
    };

    task automatic compare(input int rq, input logic eh, input logic [19:0] ep,
                           input logic [3:0] eperm, input logic [1:0] emt);
        logic [27:0] got, exp;
        got = {lk_rsp, lk_hit, lk_ppn, lk_perm, lk_mt};
        exp = {1'b1, eh, eh ? ep : 20'h0, eh ? eperm : 4'h0, eh ? emt : 2'd0};
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d lookup actual=%h expected=%h", rq, got, exp);
        end
    endtask

    task automatic lookup(input int rq, input logic [19:0] vpn, input logic eh,
                          input logic [19:0] ep, input logic [3:0] eperm, input logic [1:0] emt);
        @(negedge clk);
        lk_req = 1'b1; lk_vpn = vpn;
        @(negedge clk);
        lk_req = 1'b0;
        compare(rq, eh, ep, eperm, emt);
    endtask

    task automatic do_fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic contig,
                           input logic [3:0] perm, input logic [1:0] mt);
        @(negedge clk);
        fill = 1'b1; f_vpn = vpn; f_ppn = ppn; f_contig = contig; f_perm = perm; f_mt = mt;
        @(negedge clk);
        fill = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tests++; // R11 reset state
        if (lk_rsp !== 1'b0 || lk_hit !== 1'b0) begin
            fails++;
            $display("FAIL R11 reset actual=%b%b expected=00", lk_rsp, lk_hit);
        end

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_fill)
                do_fill(VECS[i].vpn, VECS[i].ppn, VECS[i].contig, VECS[i].perm, VECS[i].mt);
            else
                lookup(int'(VECS[i].rq), VECS[i].vpn, VECS[i].eh, VECS[i].ep,
                       VECS[i].eperm, VECS[i].emt);
        end

        // R1: idle cycle after a lookup keeps rsp low
        @(negedge clk);
        tests++;
        if (lk_rsp !== 1'b0) begin
            fails++;
            $display("FAIL R1 idle rsp actual=%b expected=0", lk_rsp);
        end

        // R10: lookup in same cycle as fill sees old state (fills last free entry)
        @(negedge clk);
        fill = 1'b1; f_vpn = 20'h00500; f_ppn = 20'h11111; f_contig = 1'b0; f_perm = 4'h1; f_mt = 2'd0;
        lk_req = 1'b1; lk_vpn = 20'h00500;
        @(negedge clk);
        fill = 1'b0; lk_req = 1'b0;
        compare(10, 1'b0, 20'h0, 4'h0, 2'd0);
        lookup(10, 20'h00500, 1'b1, 20'h11111, 4'h1, 2'd0);

        // R8: buffer full, round robin evicts entry 0 then entry 1
        do_fill(20'h00600, 20'h22222, 1'b0, 4'h1, 2'd0);
        lookup(8, 20'h00103, 1'b0, 20'h0, 4'h0, 2'd0);
        lookup(8, 20'h00600, 1'b1, 20'h22222, 4'h1, 2'd0);
        do_fill(20'h00700, 20'h33333, 1'b0, 4'h2, 2'd0);
        lookup(8, 20'h00108, 1'b0, 20'h0, 4'h0, 2'd0);
        lookup(8, 20'h0010A, 1'b1, 20'h5000A, 4'h3, 2'd1);

        // R9 + R10: flush with fill and lookup in the same cycle
        @(negedge clk);
        flush = 1'b1; fill = 1'b1; f_vpn = 20'h00900; f_ppn = 20'h44444; f_contig = 1'b0;
        lk_req = 1'b1; lk_vpn = 20'h00600;
        @(negedge clk);
        flush = 1'b0; fill = 1'b0; lk_req = 1'b0;
        compare(10, 1'b1, 20'h22222, 4'h1, 2'd0);
        lookup(9, 20'h00600, 1'b0, 20'h0, 4'h0, 2'd0);
        lookup(9, 20'h00900, 1'b0, 20'h0, 4'h0, 2'd0);

        // R5: merge takes no entry; seven more singles must not evict the group
        do_fill(20'h00800, 20'h80001, 1'b1, 4'h6, 2'd2);
        do_fill(20'h00802, 20'h80001, 1'b1, 4'h6, 2'd2);
        for (int k = 0; k < 7; k++)
            do_fill(20'h00B00 + 20'(k), 20'h0C000 + 20'(k), 1'b0, 4'h1, 2'd1);
        lookup(5, 20'h00800, 1'b1, 20'h80000, 4'h6, 2'd2);
        lookup(5, 20'h00802, 1'b1, 20'h80002, 4'h6, 2'd2);
        lookup(3, 20'h00801, 1'b0, 20'h0, 4'h0, 2'd0);
        lookup(5, 20'h00B00, 1'b1, 20'h0C000, 4'h1, 2'd1);
        lookup(5, 20'h00B06, 1'b1, 20'h0C006, 4'h1, 2'd1);

        // R8 + R9: round robin restarts at entry 0 after flush
        do_flush();
        for (int k = 0; k < 9; k++)
            do_fill(20'h00A00 + 20'(k), 20'h0D000 + 20'(k), 1'b0, 4'h4, 2'd3);
        lookup(8, 20'h00A00, 1'b0, 20'h0, 4'h0, 2'd0);
        lookup(8, 20'h00A01, 1'b1, 20'h0D001, 4'h4, 2'd3);
        lookup(8, 20'h00A02, 1'b1, 20'h0D002, 4'h4, 2'd3);
        lookup(8, 20'h00A08, 1'b1, 20'h0D008, 4'h4, 2'd3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule